// File: doc/BRIEF.md
# Free-Running Timer with Double-Buffered Compare Channels

The block is a 10-bit up-counter that runs on every enabled clock, with two compare channels that watch it. Each channel holds an active compare value and a separate holding value. Software writes the holding value through an 8-bit register bus as two byte writes, one for the top two bits and one for the low eight bits. The holding value reaches the active comparator only on the clock edge where that comparator matches the counter. Software can therefore move a match point at any time without cutting a period short or skipping one.

Each channel gives a single-cycle match pulse that a neighbouring block can use as an event. The running count can be read as two bytes. A read of the low byte latches the top two bits into a shadow. A later read of the high byte returns that shadow, so the two bytes always describe the same count.

Top module: `cmpbuf_timer`

## Requirements
- R1: After reset the counter, both active compare values, both holding values and the match outputs are zero, and every readable register returns zero.
- R2: In each clock edge with `cnt_en_i` high, the counter advances by one and wraps from 1023 to 0. With `cnt_en_i` low it holds its value.
- R3: A read of address 0xBF returns counter bits 7:0 as they stand in the cycle of the read, on `bus_rdata_o` in that same cycle.
- R4: A read of address 0xBE returns, in data bits 7:6, the counter bits 9:8 captured at the most recent read of 0xBF, with bits 5:0 at zero. Bits 7:6 are zero if 0xBF has not been read since reset.
- R5: Writing 0xB2 (channel 0) or 0xB4 (channel 1) stores data bits 7:6 as holding bits 9:8. Writing 0xB3 or 0xB5 stores data bits 7:0 as holding bits 7:0. Reads of these addresses return the holding value in the same layout, with bits 5:0 of the upper register at zero.
- R6: When `cnt_en_i` is high and the counter equals a channel's active value at a clock edge, that channel's bit of `match_o` (bit 0 for channel 0) is high for the one cycle after the edge. Otherwise it is low.
- R7: On that same matching edge, a channel whose holding register was written since its last transfer copies the holding value into its active value. Without such a write the active value stays as it is. A write in the matching cycle stays pending for the next match.
- R8: The two channels are independent: writes and matches of one never change the other's values or pulses.
- R9: Writes to 0xBE and 0xBF change nothing. A read of any address outside 0xB2 to 0xB5, 0xBE and 0xBF returns zero. `bus_rdata_o` is zero in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter advance enable |
| bus_wr_i | input | 1 | Single-cycle register write strobe |
| bus_rd_i | input | 1 | Single-cycle register read strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of `bus_rd_i` |
| match_o | output | 2 | Per-channel single-cycle match pulse |

## Verification
The assertions assume that `cnt_en_i`, the bus strobes and the address are known from the first clock after reset. They also assume that the address is steady while a strobe is high, because the read path is combinational and the counter, match and transfer properties sample these inputs at each edge. The bench sets every input to a defined value before it releases reset. It changes inputs only at falling edges or just after a rising edge, and it never drives a strobe to an unknown value. It gives a read and a write their own cycles, so the bus never carries both at once.

// File: rtl/cmpbuf_timer_pkg.sv
package cmpbuf_timer_pkg;
  localparam int          BUS_W       = 8;
  localparam logic [7:0]  CH_BASE_ADR = 8'hB2;
  localparam logic [7:0]  CNT_HI_ADR  = 8'hBE;
  localparam logic [7:0]  CNT_LO_ADR  = 8'hBF;
endpackage

// File: rtl/cmpbuf_timer_counter.sv
module cmpbuf_timer_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (en_i) cnt_o <= cnt_o + ONE;
  end
endmodule

// File: rtl/cmpbuf_timer_channel.sv
module cmpbuf_timer_channel #(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  hold_o,
  output logic [CNT_W-1:0]  act_o,
  output logic              match_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic pend_q;
  logic hit;

  assign hit = en_i && (cnt_i == act_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o  <= '0;
      act_o   <= '0;
      pend_q  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      match_o <= hit;
      if (hit && pend_q) act_o <= hold_o;
      if (wr_hi_i) hold_o[CNT_W-1:DATA_W] <= wdata_i[DATA_W-1 -: HI_W];
      if (wr_lo_i) hold_o[DATA_W-1:0]     <= wdata_i;
      // a write on the transfer edge stays pending
      if (wr_hi_i || wr_lo_i) pend_q <= 1'b1;
      else if (hit)           pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cmpbuf_timer_regif.sv
module cmpbuf_timer_regif
  import cmpbuf_timer_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int NUM_CH = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic                         rd_i,
  input  logic [7:0]                   addr_i,
  input  logic [CNT_W-1:0]             cnt_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] hold_i,
  output logic [NUM_CH-1:0]            wr_hi_o,
  output logic [NUM_CH-1:0]            wr_lo_o,
  output logic [BUS_W-1:0]             rdata_o
);
  localparam int HI_W  = CNT_W - BUS_W;
  localparam int PAD_W = BUS_W - HI_W;

  logic [HI_W-1:0]                 shadow_q;
  logic [NUM_CH-1:0][BUS_W-1:0]    ch_rd;
  logic [BUS_W-1:0]                cnt_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else if (rd_i && addr_i == CNT_LO_ADR) shadow_q <= cnt_i[CNT_W-1:BUS_W];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [7:0] HI_A = CH_BASE_ADR + 8'(2 * c);
    localparam logic [7:0] LO_A = HI_A + 8'd1;
    assign wr_hi_o[c] = wr_i && (addr_i == HI_A);
    assign wr_lo_o[c] = wr_i && (addr_i == LO_A);
    always_comb begin
      ch_rd[c] = '0;
      if (rd_i && addr_i == HI_A) ch_rd[c] = {hold_i[c][CNT_W-1:BUS_W], {PAD_W{1'b0}}};
      if (rd_i && addr_i == LO_A) ch_rd[c] = hold_i[c][BUS_W-1:0];
    end
  end

  always_comb begin
    cnt_rd = '0;
    if (rd_i && addr_i == CNT_HI_ADR) cnt_rd = {shadow_q, {PAD_W{1'b0}}};
    if (rd_i && addr_i == CNT_LO_ADR) cnt_rd = cnt_i[BUS_W-1:0];
    rdata_o = cnt_rd;
    for (int c = 0; c < NUM_CH; c++) rdata_o = rdata_o | ch_rd[c];
  end
endmodule

// File: rtl/cmpbuf_timer.sv
module cmpbuf_timer
  import cmpbuf_timer_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic [NUM_CH-1:0] match_o
);
  logic [CNT_W-1:0]             cnt_q;
  logic [NUM_CH-1:0][CNT_W-1:0] hold_w;
  logic [NUM_CH-1:0][CNT_W-1:0] act_w;
  logic [NUM_CH-1:0]            wr_hi;
  logic [NUM_CH-1:0]            wr_lo;

  cmpbuf_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cnt_en_i),
    .cnt_o (cnt_q)
  );

  cmpbuf_timer_regif #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_regif (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (bus_wr_i),
    .rd_i   (bus_rd_i),
    .addr_i (bus_addr_i),
    .cnt_i  (cnt_q),
    .hold_i (hold_w),
    .wr_hi_o(wr_hi),
    .wr_lo_o(wr_lo),
    .rdata_o(bus_rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cmpbuf_timer_channel #(.CNT_W(CNT_W), .DATA_W(BUS_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (cnt_en_i),
      .cnt_i  (cnt_q),
      .wr_hi_i(wr_hi[c]),
      .wr_lo_i(wr_lo[c]),
      .wdata_i(bus_wdata_i),
      .hold_o (hold_w[c]),
      .act_o  (act_w[c]),
      .match_o(match_o[c])
    );
  end
endmodule

// File: rtl/cmpbuf_timer_chk.sv
module cmpbuf_timer_chk
  import cmpbuf_timer_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int NUM_CH = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         cnt_en_i,
  input logic                         bus_rd_i,
  input logic [7:0]                   bus_addr_i,
  input logic [7:0]                   bus_rdata_o,
  input logic [NUM_CH-1:0]            match_o,
  input logic [CNT_W-1:0]             cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] act
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |=> cnt == $past(cnt) + ONE);

  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(cnt));

  a_r3_lo_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == CNT_LO_ADR) |-> bus_rdata_o == cnt[7:0]);

  a_r4_hi_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == CNT_HI_ADR) |-> bus_rdata_o[5:0] == 6'd0);

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> bus_rdata_o == 8'd0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    a_r6_match_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_en_i && cnt == act[c]) |=> match_o[c]);
    a_r6_no_match_else: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cnt_en_i && cnt == act[c]) |=> !match_o[c]);
    a_r7_active_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cnt_en_i && cnt == act[c]) |=> $stable(act[c]));
  end
endmodule

bind cmpbuf_timer cmpbuf_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_en_i   (cnt_en_i),
  .bus_rd_i   (bus_rd_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .match_o    (match_o),
  .cnt        (cnt_q),
  .act        (act_w)
);

// File: tb/cmpbuf_timer_tb.sv
`timescale 1ns/1ps
module cmpbuf_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] match;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, run_chk = 1'b0;

  always #2.5 clk = ~clk;

  cmpbuf_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .match_o(match)
  );

  // reference state built from the requirements
  logic [9:0]      m_cnt;
  logic [1:0][9:0] m_act, m_hold;
  logic [1:0]      m_pend, m_match;
  logic [1:0]      m_shadow;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_act <= '0; m_hold <= '0; m_pend <= '0; m_match <= '0; m_shadow <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        automatic logic hit = en && (m_cnt == m_act[c]);
        automatic logic [7:0] ha = 8'hB2 + 8'(2 * c);
        automatic logic wh = wr && addr == ha;
        automatic logic wl = wr && addr == ha + 8'd1;
        m_match[c] <= hit;
        if (hit && m_pend[c]) m_act[c] <= m_hold[c];
        if (wh) m_hold[c][9:8] <= wdata[7:6];
        if (wl) m_hold[c][7:0] <= wdata;
        if (wh || wl) m_pend[c] <= 1'b1;
        else if (hit) m_pend[c] <= 1'b0;
      end
      if (en) m_cnt <= m_cnt + 10'd1;
      if (rd && addr == 8'hBF) m_shadow <= m_cnt[9:8];
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'hBE:   return {m_shadow, 6'd0};
      8'hBF:   return m_cnt[7:0];
      8'hB2:   return {m_hold[0][9:8], 6'd0};
      8'hB3:   return m_hold[0][7:0];
      8'hB4:   return {m_hold[1][9:8], 6'd0};
      8'hB5:   return m_hold[1][7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'hBF:                      return "R3 count low read";
      8'hBE:                      return "R4 count high read";
      8'hB2, 8'hB3, 8'hB4, 8'hB5: return "R5 holding read";
      default:                    return "R9 unmapped read";
    endcase
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 check(16'(rdata), 16'(exp_rd(a)), tag);
    @(posedge clk);
    #1 rd = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  // R6 R7 R8: per-cycle pulse comparison for both channels
  always @(negedge clk) begin
    if (rst_n && run_chk) check(16'(match), 16'(m_match), "R6 R7 R8 match pulse");
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1'b1;
    @(negedge clk);
    // R1: everything at zero out of reset
    check(16'(match), 16'd0, "R1 match after reset");
    check(16'(rdata), 16'd0, "R9 idle read data");
    do_rd(8'hBF, "R1 count low");
    do_rd(8'hBE, "R1 count high");
    do_rd(8'hB2, "R1 ch0 upper"); do_rd(8'hB3, "R1 ch0 lower");
    do_rd(8'hB4, "R1 ch1 upper"); do_rd(8'hB5, "R1 ch1 lower");

    // R9: writes to count addresses are ignored
    do_wr(8'hBE, 8'hFF); do_wr(8'hBF, 8'hA5);
    do_rd(8'hBF, "R9 write to count low ignored");
    do_rd(8'hBE, "R9 write to count high ignored");

    // R5: byte layout, low six bits of upper write dropped
    do_wr(8'hB2, 8'h7F); do_wr(8'hB3, 8'h55);
    do_wr(8'hB4, 8'hBF); do_wr(8'hB5, 8'hAA);
    do_rd(8'hB2, "R5 ch0 upper"); do_rd(8'hB3, "R5 ch0 lower");
    do_rd(8'hB4, "R5 ch1 upper"); do_rd(8'hB5, "R5 ch1 lower");
    check(16'(exp_rd(8'hB2)), 16'h0040, "R5 upper layout");

    // R9 R3 R4 R5: full address sweep
    for (int a = 0; a < 256; a++) do_rd(8'(a), tag_of(8'(a)));

    // run phase: R2 count, R4 coherence, R7 transfers
    for (int i = 0; i < 3400; i++) begin
      @(negedge clk);
      en = (i < 1600) ? 1'b1 : (i % 3 != 0);
      wr = 1'b0; rd = 1'b0;
      case (i)
        300:  begin wr = 1'b1; addr = 8'hB2; wdata = 8'hC0; end
        301:  begin wr = 1'b1; addr = 8'hB3; wdata = 8'hFF; end
        700:  begin wr = 1'b1; addr = 8'hB4; wdata = 8'h00; end
        701:  begin wr = 1'b1; addr = 8'hB5; wdata = 8'h00; end
        1100: begin wr = 1'b1; addr = 8'hB3; wdata = 8'h10; end
        1700: begin wr = 1'b1; addr = 8'hB2; wdata = 8'h80; end
        1701: begin wr = 1'b1; addr = 8'hB3; wdata = 8'h80; end
        1800: begin wr = 1'b1; addr = 8'hB5; wdata = 8'h07; end
        2500: begin wr = 1'b1; addr = 8'hBF; wdata = 8'h00; end
        default: begin
          if (i % 97 == 5)  begin rd = 1'b1; addr = 8'hBF; end
          if (i % 97 == 40) begin rd = 1'b1; addr = 8'hBE; end
        end
      endcase
      if (rd) #1 check(16'(rdata), 16'(exp_rd(addr)),
                       addr == 8'hBF ? "R2 R3 running count low" : "R4 coherent count high");
    end
    @(negedge clk);
    en = 1'b0; wr = 1'b0; rd = 1'b0;
    do_rd(8'hBF, "R2 count after run");
    do_rd(8'hBE, "R4 shadow after run");
    run_chk = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule